// File: doc/BRIEF.md
# Heavy-Sink Starvation Throttle Controller

This controller sits in each node of a slotted ring and guards against receiver collisions at a destination that many nodes target at once. It counts how many slots in a row the node has held a packet without being able to send it. When that run grows past a tolerance, the node becomes the tail of a congestion path. It sends a request message upstream on the control channel, and the message names the congested destination in its collision-address field.

A node in free access that receives a request passes it on and enters limited mode for the named destination. In limited mode it may send only a fixed quota of packets to that destination. Each satisfied message refills the quota. A grant message ends the congestion path and returns every node on it to free access.

The controller drives one transmit-enable bit per destination to the node's non-FIFO buffer. Only the bit of the heavy sink is ever withdrawn, so packets for other destinations keep flowing. The buffer reports the destination of the packet considered in each slot. Message codes on both control ports are 00 idle, 01 request, 10 satisfied and 11 grant. The mode output reads 00 for free access, 01 for tail and 10 for limited.

Top module: `sink_throttle_ctrl`

## Requirements
- R1: After reset the mode is free access (00), the outgoing message is idle (00), every enable bit in `txEnMask` is 1, `limActive` is 0 and the blocked-slot count is 0.
- R2: In free access, a slot (`slotValid`=1) with `hasPkt`=1 and `txDone`=0 is a blocked slot. A slot that transmits, or that has no packet, clears the count. The (DELAY_LIMIT+1)-th blocked slot in a row raises a request (01) on the clock after that slot, with `headDest` in `txMsgAddr`.
- R3: Raising its own request puts the node in tail mode (01) with the count at 0. In tail mode the count stays at 0 and no further request is raised.
- R4: In free access, a received request (01) is passed on (01, same address) on the next clock. The node then enters limited mode (10) for that address with a full quota of QUOTA. When a request arrives in the same cycle as a node's own trigger, the received request wins.
- R5: In limited mode, each slot with `txDone`=1 and `headDest` equal to the heavy sink uses one unit of quota. Sends to other destinations use none. `limActive` is 1 while quota remains. At zero quota only the heavy sink's bit of `txEnMask` is 0. Outside that case every bit is 1.
- R6: In tail or limited mode, a received satisfied message (10) is passed on with its address on the next clock. In limited mode it also refills the quota to QUOTA, and this refill takes precedence over a same-cycle send.
- R7: In tail or limited mode, a received grant (11) is passed on with its address on the next clock. The node returns to free access with all enables at 1 and the count at 0.
- R8: Satisfied and grant messages received in free access are dropped and change nothing. Requests received in tail or limited mode are dropped.
- R9: Cycles with `slotValid`=0 neither advance nor clear the blocked-slot count, and they use no quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 1 | Marks a cycle that carries a ring slot |
| hasPkt | input | 1 | Buffer holds a packet it wants to send in this slot |
| txDone | input | 1 | A packet was sent in this slot |
| headDest | input | ADDR_W | Destination of the packet considered in this slot |
| rxMsgType | input | 2 | Received control message code |
| rxMsgAddr | input | ADDR_W | Collision address of the received message |
| txMsgType | output | 2 | Outgoing control message code, one clock per message |
| txMsgAddr | output | ADDR_W | Collision address of the outgoing message |
| mode | output | 2 | 00 free, 01 tail, 10 limited |
| limActive | output | 1 | Limited mode with quota left |
| txEnMask | output | 2**ADDR_W | Per-destination transmit enable |

## Verification
Runs of blocked slots are cut short at several lengths by a send or an empty buffer. This tells apart a counter that fires exactly past the tolerance from one that fires early, late or without clearing. Pauses in `slotValid` are mixed into both the blocked runs and the quota runs to separate slot-gated counting from cycle counting. Each message type is offered in every mode, which shows forwarding apart from dropping. A same-cycle request and own trigger fix the priority. A long random stretch, checked against the behavioural model on every clock, covers mixes of sends to the sink and to other destinations, refills and grants.

// File: rtl/sink_ctrl_pkg.sv
package sink_ctrl_pkg;
  typedef enum logic [1:0] {MSG_IDLE = 2'd0, MSG_REQ = 2'd1, MSG_SAT = 2'd2, MSG_GNT = 2'd3} msg_e;
  typedef enum logic [1:0] {ST_FREE = 2'd0, ST_TAIL = 2'd1, ST_LIM = 2'd2} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incDelay;
    logic clrDelay;
    logic loadQuota;
    logic decQuota;
    logic latchSink;
    logic send;
    logic fwdAddr;   // 1: message/sink address from received message, 0: from headDest
    msg_e msgType;
  } strobe_t;
endpackage

// File: rtl/sink_ctrl_fsm.sv
module sink_ctrl_fsm
  import sink_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    slotValid,
  input  logic    hasPkt,
  input  logic    txDone,
  input  msg_e    rxType,
  input  logic    destIsSink,
  input  logic    delayAtLimit,
  input  logic    quotaZero,
  output state_e  state,
  output strobe_t stb
);
  state_e nxtState;

  always_comb begin
    stb      = '0;
    nxtState = state;
    case (state)
      ST_FREE: begin
        if (rxType == MSG_REQ) begin
          stb.send      = 1'b1;
          stb.msgType   = MSG_REQ;
          stb.fwdAddr   = 1'b1;
          stb.latchSink = 1'b1;
          stb.loadQuota = 1'b1;
          stb.clrDelay  = 1'b1;
          nxtState      = ST_LIM;
        end else if (slotValid) begin
          if (hasPkt && !txDone) begin
            if (delayAtLimit) begin
              stb.send      = 1'b1;
              stb.msgType   = MSG_REQ;
              stb.latchSink = 1'b1;
              stb.clrDelay  = 1'b1;
              nxtState      = ST_TAIL;
            end else begin
              stb.incDelay = 1'b1;
            end
          end else begin
            stb.clrDelay = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (rxType == MSG_SAT || rxType == MSG_GNT) begin
          stb.send    = 1'b1;
          stb.msgType = rxType;
          stb.fwdAddr = 1'b1;
        end
        if (rxType == MSG_GNT) begin
          stb.clrDelay = 1'b1;
          nxtState     = ST_FREE;
        end
      end
      ST_LIM: begin
        if (rxType == MSG_SAT || rxType == MSG_GNT) begin
          stb.send    = 1'b1;
          stb.msgType = rxType;
          stb.fwdAddr = 1'b1;
        end
        if (rxType == MSG_SAT) begin
          stb.loadQuota = 1'b1;
        end else if (rxType == MSG_GNT) begin
          stb.clrDelay = 1'b1;
          nxtState     = ST_FREE;
        end else if (slotValid && txDone && destIsSink && !quotaZero) begin
          stb.decQuota = 1'b1;
        end
      end
      default: nxtState = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FREE;
    else       state <= nxtState;
  end
endmodule

// File: rtl/sink_ctrl_dp.sv
module sink_ctrl_dp
  import sink_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DELAY_LIMIT = 8,
  parameter int QUOTA       = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  state_e               state,
  input  logic [ADDR_W-1:0]    headDest,
  input  logic [ADDR_W-1:0]    rxMsgAddr,
  output logic                 delayAtLimit,
  output logic                 quotaZero,
  output logic                 destIsSink,
  output logic [1:0]           txMsgType,
  output logic [ADDR_W-1:0]    txMsgAddr,
  output logic                 limActive,
  output logic [(1<<ADDR_W)-1:0] txEnMask
);
  localparam int NUM_DEST = 1 << ADDR_W;
  localparam int DW = $clog2(DELAY_LIMIT + 1);
  localparam int QW = $clog2(QUOTA + 1);
  localparam logic [DW-1:0] DLIM  = DW'(DELAY_LIMIT);
  localparam logic [QW-1:0] QFULL = QW'(QUOTA);

  logic [DW-1:0]     delayCnt;
  logic [QW-1:0]     quotaCnt;
  logic [ADDR_W-1:0] sinkAddr;
  logic [ADDR_W-1:0] selAddr;
  msg_e              msgTypeQ;
  logic [ADDR_W-1:0] msgAddrQ;

  assign selAddr      = stb.fwdAddr ? rxMsgAddr : headDest;
  assign delayAtLimit = (delayCnt == DLIM);
  assign quotaZero    = (quotaCnt == '0);
  assign destIsSink   = (headDest == sinkAddr);
  assign limActive    = (state == ST_LIM) && !quotaZero;
  assign txMsgType    = msgTypeQ;
  assign txMsgAddr    = msgAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
      quotaCnt <= '0;
      sinkAddr <= '0;
      msgTypeQ <= MSG_IDLE;
      msgAddrQ <= '0;
    end else begin
      if (stb.clrDelay)      delayCnt <= '0;
      else if (stb.incDelay) delayCnt <= delayCnt + 1'b1;
      if (stb.loadQuota)     quotaCnt <= QFULL;
      else if (stb.decQuota) quotaCnt <= quotaCnt - 1'b1;
      if (stb.latchSink)     sinkAddr <= selAddr;
      msgTypeQ <= stb.send ? stb.msgType : MSG_IDLE;
      msgAddrQ <= stb.send ? selAddr : '0;
    end
  end

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_en
    assign txEnMask[g] = !((state == ST_LIM) && quotaZero && (sinkAddr == ADDR_W'(g)));
  end
endmodule

// File: rtl/sink_throttle_ctrl.sv
module sink_throttle_ctrl
  import sink_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DELAY_LIMIT = 8,
  parameter int QUOTA       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotValid,
  input  logic                   hasPkt,
  input  logic                   txDone,
  input  logic [ADDR_W-1:0]      headDest,
  input  logic [1:0]             rxMsgType,
  input  logic [ADDR_W-1:0]      rxMsgAddr,
  output logic [1:0]             txMsgType,
  output logic [ADDR_W-1:0]      txMsgAddr,
  output logic [1:0]             mode,
  output logic                   limActive,
  output logic [(1<<ADDR_W)-1:0] txEnMask
);
  localparam int NUM_DEST = 1 << ADDR_W;

  strobe_t stb;
  state_e  state;
  logic    delayAtLimit, quotaZero, destIsSink;

  assign mode = state;

  sink_ctrl_fsm fsm_i (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .hasPkt(hasPkt), .txDone(txDone),
    .rxType(msg_e'(rxMsgType)), .destIsSink(destIsSink), .delayAtLimit(delayAtLimit),
    .quotaZero(quotaZero), .state(state), .stb(stb)
  );

  sink_ctrl_dp #(.ADDR_W(ADDR_W), .DELAY_LIMIT(DELAY_LIMIT), .QUOTA(QUOTA)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .state(state), .headDest(headDest),
    .rxMsgAddr(rxMsgAddr), .delayAtLimit(delayAtLimit), .quotaZero(quotaZero),
    .destIsSink(destIsSink), .txMsgType(txMsgType), .txMsgAddr(txMsgAddr),
    .limActive(limActive), .txEnMask(txEnMask)
  );
endmodule

// File: rtl/sink_ctrl_chk.sv
module sink_ctrl_chk #(
  parameter int ND = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    txMsgType,
  input logic [1:0]    mode,
  input logic          limActive,
  input logic [ND-1:0] txEnMask
);
  // R4
  req_leaves_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMsgType == 2'd1) |-> (mode != 2'd0));
  // R7
  gnt_to_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMsgType == 2'd3) |-> (mode == 2'd0));
  // R8
  free_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && $past(mode) == 2'd0) |-> (txMsgType == 2'd0));
  // R5
  mask_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd2 || limActive) |-> (&txEnMask));
  // R5
  mask_one_hole_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~txEnMask) <= 1);
  // R3
  tail_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 2'd1) |-> (txMsgType != 2'd1));
endmodule

bind sink_throttle_ctrl sink_ctrl_chk #(.ND(NUM_DEST)) chk_i (
  .clk(clk), .rstN(rstN), .txMsgType(txMsgType), .mode(mode),
  .limActive(limActive), .txEnMask(txEnMask)
);

// File: tb/sink_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sink_throttle_ctrl_tb_top;
  localparam int AW = 3, ND = 8, QD = 8, QT = 4;

  logic clk = 0, rstN = 0;
  logic slotValid = 0, hasPkt = 0, txDone = 0;
  logic [AW-1:0] headDest = 0, rxMsgAddr = 0, txMsgAddr;
  logic [1:0] rxMsgType = 0, txMsgType, mode;
  logic limActive;
  logic [ND-1:0] txEnMask;

  int checks = 0, errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  sink_throttle_ctrl #(.ADDR_W(AW), .DELAY_LIMIT(QD), .QUOTA(QT)) dut_i (.*);

  // behavioural reference model
  int mState = 0, mC = 0, mQ = 0, mSink = 0, mMsgT = 0, mMsgA = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mC = 0; mQ = 0; mSink = 0; mMsgT = 0; mMsgA = 0;
    end else begin
      mMsgT = 0; mMsgA = 0;
      if (mState == 0) begin
        if (rxMsgType == 1) begin                 // R4 forward wins
          mMsgT = 1; mMsgA = rxMsgAddr; mSink = rxMsgAddr; mQ = QT; mC = 0; mState = 2;
        end else if (slotValid) begin             // R2, R9
          if (hasPkt && !txDone) begin
            if (mC >= QD) begin mMsgT = 1; mMsgA = headDest; mSink = headDest; mC = 0; mState = 1; end
            else mC++;
          end else mC = 0;
        end
      end else begin
        if (rxMsgType == 2 || rxMsgType == 3) begin mMsgT = rxMsgType; mMsgA = rxMsgAddr; end
        if (rxMsgType == 3) begin mState = 0; mC = 0; end
        else if (mState == 2) begin
          if (rxMsgType == 2) mQ = QT;            // R6
          else if (slotValid && txDone && headDest == mSink && mQ > 0) mQ--;  // R5
        end
      end
    end
  end

  function automatic logic [ND-1:0] expMask();
    logic [ND-1:0] m = '1;
    if (mState == 2 && mQ == 0) m[mSink] = 1'b0;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against model
  always @(negedge clk) if (rstN) begin
    checks++;
    if (mode != mState[1:0] || txMsgType != mMsgT[1:0] || (mMsgT != 0 && txMsgAddr != mMsgA[AW-1:0]) ||
        txEnMask != expMask() || limActive != (mState == 2 && mQ > 0)) begin
      errors++;
      $display("FAIL %s model: actual mode=%0d msg=%0d/%0d mask=%0h act=%0b expected mode=%0d msg=%0d/%0d mask=%0h act=%0b",
               phase, mode, txMsgType, txMsgAddr, txEnMask, limActive,
               mState, mMsgT, mMsgA, expMask(), (mState == 2 && mQ > 0));
    end
  end

  task automatic step(input bit sv, input bit hp, input bit td, input int dst, input int rt = 0, input int ra = 0);
    slotValid = sv; hasPkt = hp; txDone = td; headDest = dst[AW-1:0];
    rxMsgType = rt[1:0]; rxMsgAddr = ra[AW-1:0];
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    chk(txEnMask == '1 && txMsgType == 0 && !limActive, "R1 outputs", txEnMask, 8'hff);
    rstN = 1; #1;
    step(0, 0, 0, 0);

    // R2 blocked run cut by a send, then full run
    phase = "R2";
    repeat (5) step(1, 1, 0, 5);
    step(1, 1, 1, 5);
    repeat (QD) step(1, 1, 0, 5);
    chk(txMsgType == 0, "R2 no early request", txMsgType, 0);
    step(1, 1, 0, 5);
    chk(txMsgType == 1 && txMsgAddr == 5, "R2 request", {txMsgType, txMsgAddr}, {2'd1, 3'd5});
    // R3 tail mode
    phase = "R3";
    chk(mode == 1, "R3 tail", mode, 1);
    repeat (20) step(1, 1, 0, 5);
    chk(txMsgType == 0 && mode == 1, "R3 quiet in tail", txMsgType, 0);
    // R8 request dropped in tail
    phase = "R8";
    step(0, 0, 0, 0, 1, 6);
    chk(txMsgType == 0 && mode == 1, "R8 request dropped", txMsgType, 0);
    // R6 satisfied forwarded in tail
    phase = "R6";
    step(0, 0, 0, 0, 2, 5);
    chk(txMsgType == 2 && txMsgAddr == 5, "R6 sat forward", txMsgType, 2);
    // R7 grant
    phase = "R7";
    step(0, 0, 0, 0, 3, 5);
    chk(txMsgType == 3 && mode == 0 && txEnMask == '1, "R7 grant", {mode, txMsgType}, 3);
    // R8 sat/gnt ignored in free
    phase = "R8";
    step(1, 0, 0, 0, 2, 1);
    chk(txMsgType == 0 && mode == 0, "R8 sat dropped", txMsgType, 0);
    step(1, 0, 0, 0, 3, 1);
    chk(txMsgType == 0 && mode == 0, "R8 gnt dropped", txMsgType, 0);
    // R9 non-slot cycles do not count
    phase = "R9";
    repeat (20) step(0, 1, 0, 4);
    repeat (QD) step(1, 1, 0, 4);
    chk(txMsgType == 0 && mode == 0, "R9 no slot count", txMsgType, 0);
    step(1, 0, 0, 4);

    // R4 received request
    phase = "R4";
    step(0, 0, 0, 0, 1, 2);
    chk(txMsgType == 1 && txMsgAddr == 2 && mode == 2 && limActive, "R4 forward", {mode, txMsgType}, 9);
    // R5 quota
    phase = "R5";
    repeat (3) step(1, 1, 1, 3);
    repeat (3) step(1, 1, 1, 2);
    chk(limActive == 1, "R5 quota left", limActive, 1);
    step(1, 1, 1, 2);
    chk(!limActive && txEnMask == 8'hFB, "R5 sink disabled", txEnMask, 8'hFB);
    step(1, 1, 1, 2);
    chk(txEnMask == 8'hFB, "R5 stays disabled", txEnMask, 8'hFB);
    // R6 refill
    phase = "R6";
    step(1, 1, 1, 2, 2, 2);
    chk(txMsgType == 2 && limActive && txEnMask == '1, "R6 refill", txEnMask, 8'hff);
    // R9 no quota use off-slot
    phase = "R9";
    repeat (5) step(0, 1, 1, 2);
    repeat (3) step(1, 1, 1, 2);
    chk(limActive == 1, "R9 quota kept", limActive, 1);
    step(1, 1, 1, 2);
    chk(limActive == 0, "R9 quota spent", limActive, 0);
    phase = "R7";
    step(0, 0, 0, 0, 3, 2);
    chk(mode == 0 && txEnMask == '1, "R7 back to free", mode, 0);

    // R4 priority over own trigger
    phase = "R4";
    repeat (QD) step(1, 1, 0, 6);
    step(1, 1, 0, 6, 1, 4);
    chk(txMsgType == 1 && txMsgAddr == 4 && mode == 2, "R4 priority", txMsgAddr, 4);
    step(0, 0, 0, 0, 3, 4);

    // random mix, compared against the model each clock
    phase = "R2 R5 R6 random";
    for (int i = 0; i < 4000; i++) begin
      int rt = ($urandom % 10 == 0) ? int'($urandom % 4) : 0;
      bit hp = ($urandom % 4) != 0;
      step($urandom % 4 != 0, hp, hp && ($urandom % 3 == 0), int'($urandom % 4), rt, int'($urandom % 4));
    end
    finish_run();
  end
endmodule